// File: doc/BRIEF.md
# Ping-Pong Receive Buffer with Address Filter

This block sits behind a byte-stream receiver and stores each incoming frame into one of two receive buffers in a shared word-addressed memory. Bytes arrive one per `rx_valid` cycle, and `rx_last` marks the final byte of a frame. The bytes are packed into 32-bit words and written out through a simple memory write port. The first buffer starts at word 0 and the second at word `BUF_WORDS`. A frame may run on from the first buffer into the second buffer's region. It is limited only by the end of the two-buffer window.

The first six bytes carry the destination address. That address is checked against a programmed station address. A frame is kept if the address matches or if the group flag is set. A kept frame marks its buffer as full, and the buffer stays full until software releases it. With alternation enabled, the next frame then goes to the other buffer. Frames that arrive while the current buffer is full are dropped, and so are frames that are too long for the window. `rx_ready` tells the upstream side whether the current buffer can take a frame. When enabled, a one-cycle interrupt pulse reports each kept frame.

Top module: `pingpong_rx_buffer`

## Requirements
- R1: Byte k of a frame is placed in lane k mod 4 of the word at `base + k/4`, where lane 0 is bits 7:0 and `base` is 0 for buffer 0 and `BUF_WORDS` for buffer 1. A word is written on the cycle after its lane-3 byte or after the frame's last byte is taken. In a partial final word the unfilled lanes are zero.
- R2: A frame is kept when bit 7 of byte 0 is set, or when bytes 0..5 equal station bytes 0..5, where station byte k is `station_addr[8k+7:8k]`. Any other frame leaves the flags and the pointer unchanged. Such a frame writes nothing from byte 5 onward.
- R3: A frame whose first byte arrives while the current buffer is full is dropped. It performs no memory write and changes no flag or pointer.
- R4: The byte limit is `8*BUF_WORDS` when the current buffer is 0 and `4*BUF_WORDS` when it is 1. A frame of exactly the limit is kept. A longer frame is dropped, and no byte past the limit is written.
- R5: A kept frame sets the full flag of the current buffer, visible in the cycle after its last byte.
- R6: After a kept frame, `cur_buf` toggles when `pingpong_en` is 1 and holds when it is 0. It never changes otherwise.
- R7: `rx_ready` is high exactly when the current buffer's full flag is clear.
- R8: A kept frame raises `irq` for exactly one cycle, the cycle after its last byte. This happens only when `irq_global_en` is 1 and the interrupt-enable bit of buffer 0 is set. The rule is the same whichever buffer took the frame.
- R9: A cycle with `ctl_we` high loads the full flag of buffer `ctl_sel` from `ctl_s` and its interrupt-enable bit from `ctl_i`. Writing `ctl_s`=0 frees that buffer. If a kept frame ends in the same cycle, its flag set wins.
- R10: After reset, buffer 0 is current, both full flags and both enable bits are clear, and `irq` and `mem_we` are low.
- R11: A frame shorter than six bytes is never kept. Its bytes are still written per R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pingpong_en | input | 1 | Alternate buffers after each kept frame |
| station_addr | input | 48 | Station address, byte k in bits 8k+7:8k |
| irq_global_en | input | 1 | Global interrupt enable |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | This byte ends the frame |
| rx_ready | output | 1 | Current buffer can take a frame |
| ctl_we | input | 1 | Software control write strobe |
| ctl_sel | input | 1 | Buffer addressed by the control write |
| ctl_s | input | 1 | New full flag value |
| ctl_i | input | 1 | New interrupt-enable value |
| buf_full | output | 2 | Full flags, bit n for buffer n |
| cur_buf | output | 1 | Buffer that the next frame goes to |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | WADDR_W | Word address, WADDR_W = log2(2*BUF_WORDS) |
| mem_wdata | output | 32 | Packed word |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The stimulus covers four kinds of destination address: a full match, a group address that does not match, a mismatch only in the sixth byte, and a header cut short before byte six. Together these separate the match path, the group path and the point where the decision is made. A length sweep over every legal size of buffer 0 moves the last byte through all four lanes, which shows the padding of partial words. Frames one byte over the limit are run against frames exactly at the limit, for each buffer, to pin down the boundary. Busy drops, software set and release, and the interrupt gating are each run with the other conditions held fixed, so that each one shows up on its own.

// File: rtl/pprx_pkg.sv
package pprx_pkg;
  localparam int unsigned HDR_BYTES = 6;
  localparam int unsigned LANES     = 4;

  // Bytes available from the start of the selected buffer to the window end.
  function automatic int unsigned space_bytes(input logic sel, input int unsigned buf_words);
    return sel ? buf_words * LANES : 2 * buf_words * LANES;
  endfunction

  // First word of the selected buffer.
  function automatic int unsigned buf_base(input logic sel, input int unsigned buf_words);
    return sel ? buf_words : 0;
  endfunction

  // Station byte k, with byte 0 in the low bits.
  function automatic logic [7:0] addr_byte(input logic [47:0] a, input logic [2:0] k);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 6; i++)
      if (k == 3'(i)) r = a[8*i +: 8];
    return r;
  endfunction

  // Put a byte into a lane; lane 0 starts a fresh word.
  function automatic logic [31:0] merge_lane(input logic [31:0] w, input logic [1:0] lane,
                                             input logic [7:0] b);
    logic [31:0] r;
    r = (lane == 2'd0) ? 32'd0 : w;
    r[{lane, 3'b000} +: 8] = b;
    return r;
  endfunction
endpackage

// File: rtl/pprx_addr_filter.sv
module pprx_addr_filter
  import pprx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        first,
  input  logic        last,
  input  logic [2:0]  pos,
  input  logic [7:0]  byte_in,
  input  logic [47:0] station,
  output logic        hdr_done,
  output logic        hdr_pass
);
  logic match_q, group_q, pass_q;
  logic match_now, group_now, byte_eq;

  assign byte_eq   = (pos >= 3'(HDR_BYTES)) || (byte_in == addr_byte(station, pos));
  assign match_now = (first ? 1'b1 : match_q) & byte_eq;
  assign group_now = first ? byte_in[7] : group_q;
  assign hdr_done  = (pos >= 3'(HDR_BYTES - 1));
  assign hdr_pass  = (pos == 3'(HDR_BYTES - 1)) ? (group_now | match_now) : pass_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      group_q <= 1'b0;
      pass_q  <= 1'b0;
    end else if (take) begin
      if (last) begin
        match_q <= 1'b0;
        group_q <= 1'b0;
        pass_q  <= 1'b0;
      end else begin
        match_q <= match_now;
        group_q <= group_now;
        if (pos == 3'(HDR_BYTES - 1)) pass_q <= group_now | match_now;
      end
    end
  end
endmodule

// File: rtl/pprx_word_packer.sv
module pprx_word_packer
  import pprx_pkg::*;
#(
  parameter int unsigned WADDR_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               put,
  input  logic               flush,
  input  logic [1:0]         lane,
  input  logic [7:0]         byte_in,
  input  logic [WADDR_W-1:0] waddr,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [31:0]        mem_wdata
);
  logic [31:0] word_q, word_next;

  assign word_next = merge_lane(word_q, lane, byte_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= put & flush;
      if (put) begin
        word_q <= word_next;
        if (flush) begin
          mem_addr  <= waddr;
          mem_wdata <= word_next;
        end
      end
    end
  end
endmodule

// File: rtl/pprx_buf_status.sv
module pprx_buf_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_done,
  input  logic       pingpong_en,
  input  logic       irq_global_en,
  input  logic       ctl_we,
  input  logic       ctl_sel,
  input  logic       ctl_s,
  input  logic       ctl_i,
  output logic [1:0] full,
  output logic       cur,
  output logic       irq
);
  logic [1:0] ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0;
      ie_q <= '0;
      cur  <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= frame_done & irq_global_en & ie_q[0];
      if (ctl_we) begin
        full[ctl_sel] <= ctl_s;
        ie_q[ctl_sel] <= ctl_i;
      end
      if (frame_done) begin
        full[cur] <= 1'b1;
        cur       <= cur ^ pingpong_en;
      end
    end
  end
endmodule

// File: rtl/pingpong_rx_buffer.sv
module pingpong_rx_buffer
  import pprx_pkg::*;
#(
  parameter  int unsigned BUF_WORDS = 512,
  localparam int unsigned WADDR_W   = $clog2(2 * BUF_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pingpong_en,
  input  logic [47:0]        station_addr,
  input  logic               irq_global_en,
  input  logic               rx_valid,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  output logic               rx_ready,
  input  logic               ctl_we,
  input  logic               ctl_sel,
  input  logic               ctl_s,
  input  logic               ctl_i,
  output logic [1:0]         buf_full,
  output logic               cur_buf,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [31:0]        mem_wdata,
  output logic               irq
);
  localparam int unsigned CNT_W = $clog2(2 * BUF_WORDS * LANES + 1);

  logic             in_frame, busy_q, over_q;
  logic [CNT_W-1:0] byte_idx, limit;
  logic             first, busy_now, over_now, filt_reject;
  logic             wr_byte, frame_done;
  logic             hdr_done, hdr_pass;
  logic [2:0]       hdr_pos;
  logic [WADDR_W-1:0] waddr;

  assign first       = !in_frame;
  assign limit       = CNT_W'(space_bytes(cur_buf, BUF_WORDS));
  assign busy_now    = first ? buf_full[cur_buf] : busy_q;
  assign over_now    = over_q | (byte_idx >= limit);
  assign hdr_pos     = (byte_idx < CNT_W'(HDR_BYTES)) ? byte_idx[2:0] : 3'(HDR_BYTES);
  assign filt_reject = hdr_done & !hdr_pass;
  assign wr_byte     = rx_valid & !busy_now & !over_now & !filt_reject;
  assign frame_done  = rx_valid & rx_last & !busy_now & !over_now & hdr_done & hdr_pass;
  assign waddr       = WADDR_W'(buf_base(cur_buf, BUF_WORDS)) + WADDR_W'(byte_idx >> 2);
  assign rx_ready    = !buf_full[cur_buf];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      busy_q   <= 1'b0;
      over_q   <= 1'b0;
      byte_idx <= '0;
    end else if (rx_valid) begin
      if (rx_last) begin
        in_frame <= 1'b0;
        busy_q   <= 1'b0;
        over_q   <= 1'b0;
        byte_idx <= '0;
      end else begin
        in_frame <= 1'b1;
        busy_q   <= busy_now;
        over_q   <= over_now;
        if (byte_idx < limit) byte_idx <= byte_idx + 1'b1;
      end
    end
  end

  pprx_addr_filter u_filter (
    .clk(clk), .rst_n(rst_n), .take(rx_valid), .first(first), .last(rx_last),
    .pos(hdr_pos), .byte_in(rx_data), .station(station_addr),
    .hdr_done(hdr_done), .hdr_pass(hdr_pass)
  );

  pprx_word_packer #(.WADDR_W(WADDR_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .put(wr_byte), .flush((byte_idx[1:0] == 2'd3) | rx_last),
    .lane(byte_idx[1:0]), .byte_in(rx_data), .waddr(waddr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  pprx_buf_status u_status (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .pingpong_en(pingpong_en),
    .irq_global_en(irq_global_en), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
    .ctl_s(ctl_s), .ctl_i(ctl_i), .full(buf_full), .cur(cur_buf), .irq(irq)
  );
endmodule

// File: rtl/pprx_checker.sv
module pprx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pingpong_en,
  input logic       irq_global_en,
  input logic       ctl_we,
  input logic       frame_done,
  input logic [1:0] buf_full,
  input logic       cur_buf,
  input logic       rx_ready,
  input logic       irq
);
  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq);
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(frame_done && irq_global_en));
  p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pingpong_en || !frame_done) |=> $stable(cur_buf));
  p_ptr_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pingpong_en && frame_done) |=> (cur_buf != $past(cur_buf)));
  p_full_set0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !cur_buf) |=> buf_full[0]);
  p_full_set1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cur_buf) |=> buf_full[1]);
  p_full_rise0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full[0]) |-> $past(frame_done || ctl_we));
  p_full_rise1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full[1]) |-> $past(frame_done || ctl_we));
  p_ready_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(frame_done || ctl_we));
endmodule

bind pingpong_rx_buffer pprx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .irq_global_en(irq_global_en),
  .ctl_we(ctl_we), .frame_done(frame_done), .buf_full(buf_full), .cur_buf(cur_buf),
  .rx_ready(rx_ready), .irq(irq)
);

// File: tb/pingpong_rx_buffer_bench.sv
`timescale 1ns/1ps
module pingpong_rx_buffer_bench;
  localparam int unsigned BW = 4;
  localparam int unsigned AW = $clog2(2 * BW);
  localparam logic [47:0] STATION = 48'h665544332211;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pingpong_en = 1'b1, irq_global_en = 1'b1;
  logic rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0] rx_data = '0;
  logic ctl_we = 1'b0, ctl_sel = 1'b0, ctl_s = 1'b0, ctl_i = 1'b0;
  logic rx_ready, cur_buf, mem_we, irq;
  logic [1:0] buf_full;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;

  always #4 clk = ~clk;

  pingpong_rx_buffer #(.BUF_WORDS(BW)) u_pingpong_rx_buffer (
    .clk(clk), .rst_n(rst_n), .pingpong_en(pingpong_en), .station_addr(STATION),
    .irq_global_en(irq_global_en), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ready(rx_ready), .ctl_we(ctl_we), .ctl_sel(ctl_sel),
    .ctl_s(ctl_s), .ctl_i(ctl_i), .buf_full(buf_full), .cur_buf(cur_buf),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  int n_chk = 0, n_fail = 0, wr_cnt = 0, irq_cnt = 0, cyc = 0;
  logic [31:0] shadow [0:2*BW-1];
  logic [7:0]  fb [0:63];

  always @(negedge clk) begin
    if (mem_we) begin shadow[mem_addr] = mem_wdata; wr_cnt++; end
    if (irq) irq_cnt++;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      summary();
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0: matching address, 1: group address, 2: sixth byte differs
  task automatic fill(input int mode, input int len, input int seed);
    for (int i = 0; i < len; i++) fb[i] = 8'(seed + i * 13);
    for (int i = 0; i < 6; i++) begin
      if (mode == 1) fb[i] = (i == 0) ? 8'h81 : 8'(8'hA0 + i);
      else           fb[i] = STATION[8*i +: 8];
    end
    if (mode == 2) fb[5] = fb[5] ^ 8'h01;
  endtask

  task automatic send(input int len);
    for (int i = 0; i < 2 * BW; i++) shadow[i] = 32'hDEADBEEF;
    wr_cnt = 0; irq_cnt = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_data = fb[i]; rx_last = (i == len - 1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic ctl(input logic sel, input logic s, input logic i);
    @(negedge clk); ctl_we = 1'b1; ctl_sel = sel; ctl_s = s; ctl_i = i;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic check_mem(input string tag, input int base, input int len);
    for (int w = 0; w < (len + 3) / 4; w++) begin
      logic [31:0] e;
      e = '0;
      for (int b = 0; b < 4; b++)
        if (4 * w + b < len) e[8*b +: 8] = fb[4*w + b];
      chk(tag, shadow[base + w], e);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 cur", cur_buf, 0);
    chk("R10 full", buf_full, 0);
    chk("R10 ready", rx_ready, 1);
    chk("R10 irq", irq, 0);
    chk("R10 mem_we", mem_we, 0);

    ctl(1'b0, 1'b0, 1'b1);
    // R1 R5 R6 R8: matching frame of 10 bytes into buffer 0
    fill(0, 10, 3); send(10);
    check_mem("R1 buf0 word", 0, 10);
    chk("R1 write count", wr_cnt, 3);
    chk("R5 full after buf0", buf_full, 2'b01);
    chk("R6 toggle", cur_buf, 1);
    chk("R8 irq buf0", irq_cnt, 1);

    // R2 group address into buffer 1, R7 ready low
    fill(1, 7, 40); send(7);
    check_mem("R1 buf1 word", BW, 7);
    chk("R5 full both", buf_full, 2'b11);
    chk("R6 toggle back", cur_buf, 0);
    chk("R7 ready low", rx_ready, 0);
    chk("R8 irq via buf0 enable", irq_cnt, 1);

    // R3 busy drop
    fill(0, 8, 77); send(8);
    chk("R3 busy no write", wr_cnt, 0);
    chk("R3 busy flags", buf_full, 2'b11);
    chk("R3 busy ptr", cur_buf, 0);
    chk("R3 busy irq", irq_cnt, 0);

    // R9 software release
    ctl(1'b0, 1'b0, 1'b1);
    chk("R9 release buf0", buf_full, 2'b10);
    chk("R7 ready high", rx_ready, 1);
    ctl(1'b1, 1'b0, 1'b0);
    chk("R9 release buf1", buf_full, 2'b00);

    // R2 mismatch in sixth byte
    fill(2, 12, 9); send(12);
    chk("R2 reject writes", wr_cnt, 1);
    check_mem("R2 reject first word", 0, 4);
    chk("R2 reject flags", buf_full, 0);
    chk("R2 reject ptr", cur_buf, 0);
    chk("R2 reject irq", irq_cnt, 0);

    // R11 short frame
    fill(0, 5, 21); send(5);
    chk("R11 short writes", wr_cnt, 2);
    check_mem("R11 short words", 0, 5);
    chk("R11 short flags", buf_full, 0);

    // R4 limits for buffer 0 (32 bytes) and buffer 1 (16 bytes)
    fill(0, 33, 5); send(33);
    chk("R4 over0 writes", wr_cnt, 8);
    check_mem("R4 over0 words", 0, 32);
    chk("R4 over0 flags", buf_full, 0);
    fill(0, 32, 6); send(32);
    check_mem("R4 exact0 words", 0, 32);
    chk("R4 exact0 flags", buf_full, 2'b01);
    chk("R4 exact0 ptr", cur_buf, 1);
    fill(1, 17, 7); send(17);
    chk("R4 over1 writes", wr_cnt, 4);
    chk("R4 over1 flags", buf_full, 2'b01);
    fill(1, 16, 8); send(16);
    check_mem("R4 exact1 words", BW, 16);
    chk("R4 exact1 flags", buf_full, 2'b11);
    chk("R4 exact1 ptr", cur_buf, 0);

    // R8 gating
    ctl(1'b0, 1'b0, 1'b1); ctl(1'b1, 1'b0, 1'b0);
    irq_global_en = 1'b0;
    fill(0, 6, 1); send(6);
    chk("R8 global off", irq_cnt, 0);
    chk("R5 len6 kept", buf_full, 2'b01);
    ctl(1'b0, 1'b0, 1'b0);
    irq_global_en = 1'b1;
    fill(0, 6, 2); send(6);
    chk("R8 buf0 enable off", irq_cnt, 0);
    chk("R5 buf1 kept", buf_full, 2'b10);
    ctl(1'b0, 1'b0, 1'b1); ctl(1'b1, 1'b0, 1'b0);

    // R9 software set makes a buffer busy
    ctl(1'b1, 1'b1, 1'b0);
    chk("R9 set buf1", buf_full, 2'b10);
    chk("R7 ready other buf", rx_ready, 1);
    ctl(1'b0, 1'b1, 1'b1);
    chk("R7 ready after set", rx_ready, 0);
    ctl(1'b0, 1'b0, 1'b1); ctl(1'b1, 1'b0, 1'b0);

    // Sweep all lengths with alternation off, R1 R6
    pingpong_en = 1'b0;
    for (int len = 6; len <= 32; len++) begin
      ctl(1'b0, 1'b0, 1'b1);
      fill(len % 2, len, len * 3);
      send(len);
      check_mem("R1 sweep word", 0, len);
      chk("R1 sweep count", wr_cnt, (len + 3) / 4);
      chk("R6 hold", cur_buf, 0);
      chk("R5 sweep full", buf_full[0], 1);
    end
    summary();
  end
endmodule